// File: doc/BRIEF.md
# Dual-Lane Serial Sample Packet Receiver

This block receives sample packets from two asynchronous serial lanes (8 data bits, no parity, one stop bit, least significant bit first) on the controller side of a sensor link. Each packet is three bytes. The first byte is a header that names one of four channels on its lane. The next two bytes carry that channel's 16-bit sample, high byte first. The two lanes are decoded in parallel and together fill eight sample registers. Lane 0 feeds channels 0 to 3 and lane 1 feeds channels 4 to 7.

Software asks for a fresh set of samples by pulsing a request input. The block toggles a request line toward the remote side for each pulse. A new-data flag rises once all eight channels have been refreshed since the last request, and a bus read strobe clears it. A sticky valid flag shows that every channel has held at least one sample since reset.

Three saturating counters record link health: bytes accepted, bytes rejected as corrupt, and packets abandoned on an inter-byte timeout. Software can clear all three counters together.

Top module: `sample_link_rx`

## Requirements
- R1: A header byte 0x90+k (k = 0..3) received on lane L, followed by bytes H then L0, loads sample_o[16*(4*L+k) +: 16] with {H, L0}.
- R2: Both lanes decode at the same time, so packets arriving together on lane 0 and lane 1 both update their channels.
- R3: cnt_valid_o rises by one for each byte with a high stop bit that the parser accepts (an in-range header or a data byte).
- R4: cnt_corrupt_o rises by one for each byte whose stop bit is low, and for each byte outside 0x90..0x93 received where a header is expected. The partial packet is dropped, and the next in-range header starts a new packet.
- R5: If a packet's next byte does not arrive within TIMEOUT_BITS bit times of the previous one, the packet is dropped, cnt_timeout_o rises by one, and the channel keeps its old value.
- R6: A channel register changes only after both of its data bytes arrive with good stop bits.
- R7: Each one-cycle pulse on req_i toggles req_o once, on the following clock edge.
- R8: new_data_o sets on the edge where the last of the eight channels is written after the latest req_i pulse. It clears on rd_i. A set in the same cycle wins over the clear.
- R9: data_valid_o goes high once every channel has been written since reset, and it stays high.
- R10: The counters are CNT_W bits wide and hold at 2^CNT_W-1 instead of wrapping. A clr_cnt_i pulse sets all three to zero.
- R11: After reset, all samples, counters, req_o, new_data_o and data_valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | LANES | Serial receive lines, one per lane |
| req_i | input | 1 | Software request pulse |
| rd_i | input | 1 | Bus read strobe; clears new_data_o |
| clr_cnt_i | input | 1 | Clears the three counters |
| req_o | output | 1 | Request line, toggled once per request |
| sample_o | output | 16*4*LANES | Channel samples, channel c at bits 16*c +: 16 |
| cnt_valid_o | output | CNT_W | Accepted byte count |
| cnt_corrupt_o | output | CNT_W | Corrupt byte count |
| cnt_timeout_o | output | CNT_W | Timed-out packet count |
| data_valid_o | output | 1 | Every channel has been loaded since reset |
| new_data_o | output | 1 | All channels refreshed since the last request |

## Verification
The bench first sends full packets on both lanes at once with distinct values per channel, which confirms the channel mapping and that the lanes are independent. It then sends an out-of-range header followed by a good packet, which separates the rejection path from resynchronisation. A data byte with a low stop bit shows that a bad byte drops the partial packet and leaves the channel untouched. Two gap tests tell a gap that is still legal apart from one that expires the timeout. Refreshing only one lane after a request shows that the new-data flag needs all eight channels. The bench runs with narrow counters, so a long burst of packets drives the valid count to its limit, and the saturation and clear paths are checked against arithmetic kept in the bench.

// File: rtl/sample_link_pkg.sv
package sample_link_pkg;
  localparam int unsigned CH_PER_LANE = 4;
  localparam logic [7:0]  HDR_BASE    = 8'h90;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {PK_HDR, PK_HI, PK_LO} pk_state_e;
endpackage

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import sample_link_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic       byte_v_o,
  output logic [7:0] byte_o,
  output logic       stop_ok_o
);
  localparam int unsigned HALF  = CLKS_PER_BIT / 2;
  localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT + 1);

  logic [1:0]       sync_q;
  rx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       shf_q;
  logic             rx_s;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      st_q      <= RX_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shf_q     <= '0;
      byte_v_o  <= 1'b0;
      byte_o    <= '0;
      stop_ok_o <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], rx_i};
      byte_v_o <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) st_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? RX_IDLE : RX_DATA;  // reject glitches
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (cnt_q == CNT_W'(CLKS_PER_BIT - 1)) begin
            cnt_q <= '0;
            shf_q <= {rx_s, shf_q[7:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) st_q <= RX_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (cnt_q == CNT_W'(CLKS_PER_BIT - 1)) begin
            cnt_q     <= '0;
            byte_v_o  <= 1'b1;
            byte_o    <= shf_q;
            stop_ok_o <= rx_s;
            st_q      <= RX_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sample_frame_parser.sv
module sample_frame_parser
  import sample_link_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 80
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_v_i,
  input  logic [7:0]  byte_i,
  input  logic        stop_ok_i,
  output logic        ok_o,
  output logic        bad_o,
  output logic        tmo_o,
  output logic        wr_o,
  output logic [1:0]  wr_ch_o,
  output logic [15:0] wr_data_o
);
  localparam int unsigned TMR_W = $clog2(TIMEOUT_CLKS + 1);

  pk_state_e        st_q, st_d;
  logic [1:0]       ch_q, ch_d;
  logic [7:0]       hi_q, hi_d;
  logic [TMR_W-1:0] tmr_q;
  logic             hdr_ok;

  assign hdr_ok    = (byte_i[7:2] == HDR_BASE[7:2]);
  assign wr_ch_o   = ch_q;
  assign wr_data_o = {hi_q, byte_i};

  always_comb begin
    st_d  = st_q;
    ch_d  = ch_q;
    hi_d  = hi_q;
    ok_o  = 1'b0;
    bad_o = 1'b0;
    tmo_o = 1'b0;
    wr_o  = 1'b0;
    if (byte_v_i) begin
      if (!stop_ok_i) begin
        bad_o = 1'b1;
        st_d  = PK_HDR;
      end else begin
        case (st_q)
          PK_HDR: begin
            if (hdr_ok) begin
              ok_o = 1'b1;
              ch_d = byte_i[1:0];
              st_d = PK_HI;
            end else bad_o = 1'b1;
          end
          PK_HI: begin
            ok_o = 1'b1;
            hi_d = byte_i;
            st_d = PK_LO;
          end
          default: begin
            ok_o = 1'b1;
            wr_o = 1'b1;
            st_d = PK_HDR;
          end
        endcase
      end
    end else if (st_q != PK_HDR && tmr_q == TMR_W'(TIMEOUT_CLKS - 1)) begin
      tmo_o = 1'b1;
      st_d  = PK_HDR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PK_HDR;
      ch_q  <= '0;
      hi_q  <= '0;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      ch_q <= ch_d;
      hi_q <= hi_d;
      if (byte_v_i || st_q == PK_HDR) tmr_q <= '0;
      else                            tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W:0] sum;

  assign sum = {1'b0, cnt_o} + (W + 1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (sum[W]) cnt_o <= '1;
    else             cnt_o <= sum[W-1:0];
  end
endmodule

// File: rtl/sample_link_rx.sv
module sample_link_rx
  import sample_link_pkg::*;
#(
  parameter int unsigned LANES        = 2,
  parameter int unsigned CLKS_PER_BIT = 4,
  parameter int unsigned TIMEOUT_BITS = 20,
  parameter int unsigned CNT_W        = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [LANES-1:0]                  rx_i,
  input  logic                              req_i,
  input  logic                              rd_i,
  input  logic                              clr_cnt_i,
  output logic                              req_o,
  output logic [16*CH_PER_LANE*LANES-1:0]   sample_o,
  output logic [CNT_W-1:0]                  cnt_valid_o,
  output logic [CNT_W-1:0]                  cnt_corrupt_o,
  output logic [CNT_W-1:0]                  cnt_timeout_o,
  output logic                              data_valid_o,
  output logic                              new_data_o
);
  localparam int unsigned NUM_CH       = CH_PER_LANE * LANES;
  localparam int unsigned TIMEOUT_CLKS = TIMEOUT_BITS * CLKS_PER_BIT;
  localparam int unsigned INC_W        = $clog2(LANES + 1);

  logic [LANES-1:0] ok_v, bad_v, tmo_v, wr_v;
  logic [1:0]       wr_ch  [LANES];
  logic [15:0]      wr_dat [LANES];
  logic [15:0]      samp_q [NUM_CH];
  logic [NUM_CH-1:0] wr_ch_v, fresh_q, fresh_d, seen_q;
  logic [INC_W-1:0] inc_ok, inc_bad, inc_tmo;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       bv, sok;
    logic [7:0] bd;

    serial_byte_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
      .clk_i, .rst_ni, .rx_i(rx_i[l]),
      .byte_v_o(bv), .byte_o(bd), .stop_ok_o(sok)
    );

    sample_frame_parser #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_pk (
      .clk_i, .rst_ni, .byte_v_i(bv), .byte_i(bd), .stop_ok_i(sok),
      .ok_o(ok_v[l]), .bad_o(bad_v[l]), .tmo_o(tmo_v[l]),
      .wr_o(wr_v[l]), .wr_ch_o(wr_ch[l]), .wr_data_o(wr_dat[l])
    );

    for (genvar k = 0; k < CH_PER_LANE; k++) begin : g_ch
      localparam int unsigned C = l * CH_PER_LANE + k;
      assign wr_ch_v[C] = wr_v[l] && (wr_ch[l] == 2'(k));
      assign sample_o[16*C +: 16] = samp_q[C];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         samp_q[C] <= '0;
        else if (wr_ch_v[C]) samp_q[C] <= wr_dat[l];
      end
    end
  end

  always_comb begin
    inc_ok  = '0;
    inc_bad = '0;
    inc_tmo = '0;
    for (int l = 0; l < LANES; l++) begin
      inc_ok  = inc_ok  + INC_W'(ok_v[l]);
      inc_bad = inc_bad + INC_W'(bad_v[l]);
      inc_tmo = inc_tmo + INC_W'(tmo_v[l]);
    end
  end

  sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt_ok (
    .clk_i, .rst_ni, .clr_i(clr_cnt_i), .inc_i(inc_ok), .cnt_o(cnt_valid_o));
  sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt_bad (
    .clk_i, .rst_ni, .clr_i(clr_cnt_i), .inc_i(inc_bad), .cnt_o(cnt_corrupt_o));
  sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_cnt_tmo (
    .clk_i, .rst_ni, .clr_i(clr_cnt_i), .inc_i(inc_tmo), .cnt_o(cnt_timeout_o));

  assign fresh_d      = req_i ? '0 : (fresh_q | wr_ch_v);
  assign data_valid_o = &seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      fresh_q    <= '0;
      seen_q     <= '0;
      new_data_o <= 1'b0;
    end else begin
      fresh_q <= fresh_d;
      seen_q  <= seen_q | wr_ch_v;
      if (req_i) req_o <= ~req_o;
      if (!(&fresh_q) && (&fresh_d)) new_data_o <= 1'b1;
      else if (rd_i)                 new_data_o <= 1'b0;
    end
  end
endmodule

module sample_link_rx_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SW    = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             rd_i,
  input logic             clr_cnt_i,
  input logic             req_o,
  input logic [SW-1:0]    sample_o,
  input logic [CNT_W-1:0] cnt_valid_o,
  input logic             data_valid_o,
  input logic             new_data_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r7_req_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (req_o != $past(req_o)));
  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(req_o));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cnt_i |=> (cnt_valid_o == '0));
  a_r10_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_cnt_i && cnt_valid_o == CMAX) |=> (cnt_valid_o == CMAX));
  a_r3_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_cnt_i |=> (cnt_valid_o >= $past(cnt_valid_o)));
  a_r9_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> data_valid_o);
  a_r8_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(new_data_o) |-> $past(rd_i));
  a_r6_sample_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_o) |-> ($past(clr_cnt_i) || $past(cnt_valid_o) == CMAX
                            || cnt_valid_o != $past(cnt_valid_o)));
endmodule

bind sample_link_rx sample_link_rx_chk #(
  .CNT_W(CNT_W), .SW(16 * sample_link_pkg::CH_PER_LANE * LANES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rd_i(rd_i),
  .clr_cnt_i(clr_cnt_i), .req_o(req_o), .sample_o(sample_o),
  .cnt_valid_o(cnt_valid_o), .data_valid_o(data_valid_o),
  .new_data_o(new_data_o)
);

// File: tb/sim_sample_link_rx.sv
module sim_sample_link_rx;
  localparam int CPB = 4;
  localparam int TOB = 20;
  localparam int CW  = 5;
  localparam int NCH = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rx = 2'b11;
  logic req = 1'b0, rd = 1'b0, clr = 1'b0;
  logic req_o, dv, nd;
  logic [16*NCH-1:0] samp;
  logic [CW-1:0] cv, cc, ct;

  int checks = 0, errors = 0;
  int ev = 0, ec = 0, et = 0;
  logic [15:0] exp_s [NCH];
  bit done = 0;

  always #5 clk = ~clk;

  sample_link_rx #(.LANES(2), .CLKS_PER_BIT(CPB), .TIMEOUT_BITS(TOB), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .req_i(req), .rd_i(rd),
    .clr_cnt_i(clr), .req_o(req_o), .sample_o(samp), .cnt_valid_o(cv),
    .cnt_corrupt_o(cc), .cnt_timeout_o(ct), .data_valid_o(dv), .new_data_o(nd));

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  function automatic logic [15:0] pat(input int ch, input int k);
    return 16'((ch + 1) * 16'h1111) ^ 16'(k * 16'h00f3);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, expv);
    end
  endtask

  task automatic idle(input int bits);
    repeat (bits * CPB) @(negedge clk);
  endtask

  task automatic send_byte(input int ln, input logic [7:0] b, input logic stp);
    @(negedge clk);
    rx[ln] = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx[ln] = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx[ln] = stp;
    repeat (CPB) @(negedge clk);
    rx[ln] = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_pkt(input int ln, input int k, input logic [15:0] v);
    send_byte(ln, 8'h90 + 8'(k), 1'b1);
    send_byte(ln, v[15:8], 1'b1);
    send_byte(ln, v[7:0], 1'b1);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic fill_all(input int seed);
    for (int k = 0; k < 4; k++) begin
      fork
        send_pkt(0, k, pat(k, seed));
        send_pkt(1, k, pat(k + 4, seed));
      join
      exp_s[k] = pat(k, seed);
      exp_s[k + 4] = pat(k + 4, seed);
      ev = sat(ev + 6);
    end
    idle(2);
  endtask

  task automatic chk_samples(input string r);
    for (int c = 0; c < NCH; c++) chk(r, samp[16*c +: 16], exp_s[c]);
  endtask

  task automatic chk_cnts(input string r);
    chk({r, " valid"}, cv, ev);
    chk({r, " corrupt"}, cc, ec);
    chk({r, " timeout"}, ct, et);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_s[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 samples", 32'(samp != '0), 0);
    chk_cnts("R11");
    chk("R11 req_o", req_o, 0);
    chk("R11 new_data", nd, 0);
    chk("R11 data_valid", dv, 0);

    // R7 request toggles
    pulse(req);
    chk("R7 toggle1", req_o, 1);
    pulse(req);
    chk("R7 toggle2", req_o, 0);
    idle(1);
    chk("R7 hold", req_o, 0);

    // R1 R2 both lanes, all channels
    fill_all(1);
    chk_samples("R1 R2 map");
    chk_cnts("R3 after fill");
    chk("R8 new_data set", nd, 1);
    chk("R9 data_valid", dv, 1);
    pulse(rd);
    chk("R8 read clears", nd, 0);

    // R4 bad header, then resync
    send_byte(0, 8'h94, 1'b1);
    ec = sat(ec + 1);
    send_byte(0, 8'h8f, 1'b1);
    ec = sat(ec + 1);
    send_pkt(0, 2, 16'hbeef);
    exp_s[2] = 16'hbeef;
    ev = sat(ev + 3);
    idle(2);
    chk("R4 resync sample", samp[32 +: 16], 16'hbeef);
    chk_cnts("R4 bad header");

    // R6 low stop bit on data byte drops the packet
    send_byte(0, 8'h90, 1'b1);
    send_byte(0, 8'h55, 1'b0);
    send_byte(0, 8'h12, 1'b1);
    ev = sat(ev + 1);
    ec = sat(ec + 2);
    idle(2);
    chk("R6 ch0 unchanged", samp[0 +: 16], exp_s[0]);
    chk_cnts("R4 R6 stop low");

    // R5 gap within limit still completes
    send_byte(1, 8'h91, 1'b1);
    idle(4);
    send_byte(1, 8'h3c, 1'b1);
    send_byte(1, 8'ha5, 1'b1);
    exp_s[5] = 16'h3ca5;
    ev = sat(ev + 3);
    idle(2);
    chk("R5 short gap ok", samp[80 +: 16], 16'h3ca5);

    // R5 expired gap
    send_byte(1, 8'h93, 1'b1);
    send_byte(1, 8'h77, 1'b1);
    idle(TOB + 10);
    send_byte(1, 8'h66, 1'b1);
    ev = sat(ev + 2);
    et = sat(et + 1);
    ec = sat(ec + 1);
    idle(2);
    chk("R5 ch7 unchanged", samp[112 +: 16], exp_s[7]);
    chk_cnts("R5 timeout");

    // R8 partial refresh does not set new_data
    pulse(req);
    for (int k = 0; k < 4; k++) begin
      send_pkt(0, k, pat(k, 7));
      exp_s[k] = pat(k, 7);
      ev = sat(ev + 3);
    end
    idle(2);
    chk("R8 partial no flag", nd, 0);
    for (int k = 0; k < 4; k++) begin
      send_pkt(1, k, pat(k + 4, 7));
      exp_s[k + 4] = pat(k + 4, 7);
      ev = sat(ev + 3);
    end
    idle(2);
    chk("R8 full flag", nd, 1);
    chk_samples("R1 lane order");
    chk_cnts("R10 saturation");
    chk("R10 at max", cv, MAXC);
    chk("R9 still valid", dv, 1);

    // R10 clear then count again
    pulse(clr);
    ev = 0; ec = 0; et = 0;
    chk_cnts("R10 cleared");
    fill_all(3);
    chk_samples("R2 second pattern");
    chk_cnts("R3 recount");
    fill_all(4);
    fill_all(5);
    chk_cnts("R10 sat again");
    chk("R8 no request no flag change", nd, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule